// File: doc/BRIEF.md
# Four-phase frame sequencer

This block paces one node of a replicated, fault-tolerant computer through its repeating frame. Each frame has four phases in a fixed order. In the compute phase the node runs its tasks and loads its outgoing results. In the broadcast phase it only waits for the results to reach the other replicas. In the vote phase it reads the replicated copies, votes on them and writes the winners back. In the sync phase an external synchronizer adjusts the node's clock. The computation logic ends each of the first three phases with a done strobe. The synchronizer ends the sync phase by delivering a signed correction.

The sequencer counts how many cycles each non-sync phase actually lasts. It flags a phase whose length leaves the band set by a nominal duration and a fractional tolerance. It numbers the frames and accumulates the corrections it accepts into a cumulative offset. It also publishes a synchronized time: the raw cycle count plus that offset. A correction whose magnitude reaches the configured bound is refused and reported. Because the offset changes only when the sync phase ends, the synchronized time steps by one every cycle except at that one point, where it can jump.

Top module: `frame_phase_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the phase is compute, `frame_no`, `cum_corr` and `sync_time` are 0, `dur_err` and `corr_err` are 0, and `phase_start` is 1.
- R2: `phase` is one-hot, with bit 0 for compute, bit 1 for broadcast, bit 2 for vote and bit 3 for sync. It moves only in the order compute, broadcast, vote, sync and back to compute. A non-sync phase ends on the clock edge that samples `phase_done` high. The sync phase ends on the edge that samples `corr_valid` high.
- R3: `phase_start` is 1 exactly in the first cycle of each phase and 0 in every other cycle.
- R4: The duration A of a non-sync phase is the number of cycles it occupies, counting the cycle in which `phase_done` is sampled. If A falls outside [ceil(D·(DEN−NUM)/DEN), floor(D·(DEN+NUM)/DEN)], `dur_err` is 1 for the first cycle of the next phase. With the default parameters the bands are 28..36 for compute (D=32), 14..18 for broadcast (D=16) and 21..27 for vote (D=24). `dur_err` is 0 at all other times.
- R5: `phase_done` has no effect during sync, and `corr_valid` has no effect outside sync. Neither changes the phase, `frame_no` or `cum_corr`.
- R6: `frame_no` increases by one, modulo 2^FRAME_W, on the edge that ends the sync phase, and at no other time.
- R7: When the sync phase ends with |`corr_value`| < CORR_LIMIT (64 by default), the two's-complement `corr_value` is sign-extended and added to `cum_corr`.
- R8: When the sync phase ends with |`corr_value`| ≥ CORR_LIMIT, `cum_corr` keeps its value, `corr_err` is 1 for the first cycle of the next compute phase, and the frame still advances. `corr_err` is 0 at all other times.
- R9: `sync_time` equals the number of clock edges since reset was released plus the sign-extended `cum_corr`. Apart from the cycle right after a sync phase ends, it rises by exactly one per cycle.
- R10: `cfg_err` is 1 after reset only if the nominal broadcast duration is shorter than the delivery deadline DELIVER_CYC. With the default parameters it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_done | input | 1 | Computation logic finished the current non-sync phase |
| corr_valid | input | 1 | Synchronizer presents a correction, ending the sync phase |
| corr_value | input | CORR_W | Signed clock correction in cycles |
| phase | output | 4 | One-hot current phase |
| phase_start | output | 1 | First cycle of the current phase |
| frame_no | output | FRAME_W | Frame number |
| cum_corr | output | CUM_W | Signed cumulative accepted correction |
| sync_time | output | TIME_W | Raw cycle count plus cumulative correction |
| dur_err | output | 1 | Previous non-sync phase length was out of tolerance |
| corr_err | output | 1 | Last correction was refused as too large |
| cfg_err | output | 1 | Broadcast nominal length is below the delivery deadline |

## Verification
Several properties are checked every cycle: the phase stays one-hot and moves only to its successor, the frame number and the offset change only as a sync phase closes, a refused correction leaves the offset untouched, and the synchronized time advances by one everywhere except at the sync exit. Whether a given length is judged in or out of tolerance, and whether a given correction is accepted or refused, can only be shown by the scenarios. These drive each phase at lengths on and just beyond both edges of its band, and drive corrections at ±63, ±64 and the most negative value. The scenarios also show that the sync phase holds on a stray done strobe and that a stray correction during compute leaves the offset untouched.

// File: rtl/frame_phase_seq.sv
module frame_phase_seq #(
  parameter int CMP_NOM     = 32,
  parameter int BC_NOM      = 16,
  parameter int VOT_NOM     = 24,
  parameter int TOL_NUM     = 1,
  parameter int TOL_DEN     = 8,
  parameter int DELIVER_CYC = 12,
  parameter int CORR_W      = 8,
  parameter int CORR_LIMIT  = 64,
  parameter int CUM_W       = 16,
  parameter int FRAME_W     = 16,
  parameter int TIME_W      = 32,
  parameter int CNT_W       = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     phase_done,
  input  logic                     corr_valid,
  input  logic signed [CORR_W-1:0] corr_value,
  output logic [3:0]               phase,
  output logic                     phase_start,
  output logic [FRAME_W-1:0]       frame_no,
  output logic signed [CUM_W-1:0]  cum_corr,
  output logic [TIME_W-1:0]        sync_time,
  output logic                     dur_err,
  output logic                     corr_err,
  output logic                     cfg_err
);

  localparam int CMP_LO = (CMP_NOM * (TOL_DEN - TOL_NUM) + TOL_DEN - 1) / TOL_DEN;
  localparam int CMP_HI = (CMP_NOM * (TOL_DEN + TOL_NUM)) / TOL_DEN;
  localparam int BC_LO  = (BC_NOM * (TOL_DEN - TOL_NUM) + TOL_DEN - 1) / TOL_DEN;
  localparam int BC_HI  = (BC_NOM * (TOL_DEN + TOL_NUM)) / TOL_DEN;
  localparam int VOT_LO = (VOT_NOM * (TOL_DEN - TOL_NUM) + TOL_DEN - 1) / TOL_DEN;
  localparam int VOT_HI = (VOT_NOM * (TOL_DEN + TOL_NUM)) / TOL_DEN;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CORR_W:0]  LIMIT   = (CORR_W+1)'(CORR_LIMIT);

  logic [3:0]        ph;
  logic [CNT_W-1:0]  cnt, lo, hi;
  logic [TIME_W-1:0] raw_time;

  wire in_sync = ph[3];
  wire advance = in_sync ? corr_valid : phase_done;

  always_comb begin
    lo = CNT_W'(VOT_LO);
    hi = CNT_W'(VOT_HI);
    if (ph[0]) begin
      lo = CNT_W'(CMP_LO);
      hi = CNT_W'(CMP_HI);
    end else if (ph[1]) begin
      lo = CNT_W'(BC_LO);
      hi = CNT_W'(BC_HI);
    end
  end

  wire signed [CORR_W:0] cv_ext = {corr_value[CORR_W-1], corr_value};
  wire [CORR_W:0]        cv_mag = cv_ext[CORR_W] ? (CORR_W+1)'(-cv_ext) : cv_ext;
  wire                   corr_ok = cv_mag < LIMIT;
  wire signed [CUM_W-1:0] cv_wide = {{(CUM_W-CORR_W){corr_value[CORR_W-1]}}, corr_value};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 4'b0001;
      cnt      <= CNT_W'(1);
      frame_no <= '0;
      cum_corr <= '0;
      raw_time <= '0;
      dur_err  <= 1'b0;
      corr_err <= 1'b0;
      cfg_err  <= (BC_NOM < DELIVER_CYC);
    end else begin
      raw_time <= raw_time + 1'b1;
      dur_err  <= advance && !in_sync && ((cnt < lo) || (cnt > hi));
      corr_err <= advance && in_sync && !corr_ok;
      if (advance) begin
        ph  <= {ph[2:0], ph[3]};
        cnt <= CNT_W'(1);
        if (in_sync) begin
          frame_no <= frame_no + 1'b1;
          if (corr_ok) cum_corr <= cum_corr + cv_wide;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign phase       = ph;
  assign phase_start = (cnt == CNT_W'(1));
  assign sync_time   = raw_time + {{(TIME_W-CUM_W){cum_corr[CUM_W-1]}}, cum_corr};

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot(phase));

  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == {$past(phase[2:0]), $past(phase[3])}));

  p_err_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    (dur_err || corr_err) |-> phase_start);

  p_frame_only_sync_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_no != $past(frame_no)) |-> ($past(phase[3]) && phase[0]));

  p_cum_only_sync_r7: assert property (@(posedge clk) disable iff (rst)
    (cum_corr != $past(cum_corr)) |-> ($past(phase[3]) && $past(corr_valid)));

  p_refused_keeps_cum_r8: assert property (@(posedge clk) disable iff (rst)
    corr_err |-> ($stable(cum_corr) && phase[0]));

  p_time_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(phase[3]) && phase[0])) |-> (sync_time == $past(sync_time) + 1'b1));

endmodule

// File: tb/frame_phase_seq_tb.sv
module frame_phase_seq_tb;
  localparam int CW = 8, UW = 16, FW = 16, TW = 32;

  logic clk = 1'b0, rst = 1'b1, phase_done = 1'b0, corr_valid = 1'b0;
  logic signed [CW-1:0] corr_value = '0;
  logic [3:0] phase;
  logic phase_start, dur_err, corr_err, cfg_err;
  logic [FW-1:0] frame_no;
  logic signed [UW-1:0] cum_corr;
  logic [TW-1:0] sync_time;

  frame_phase_seq u_dut (
    .clk(clk), .rst(rst), .phase_done(phase_done), .corr_valid(corr_valid),
    .corr_value(corr_value), .phase(phase), .phase_start(phase_start),
    .frame_no(frame_no), .cum_corr(cum_corr), .sync_time(sync_time),
    .dur_err(dur_err), .corr_err(corr_err), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0] ph;
    logic [FW-1:0] fr;
    logic signed [UW-1:0] cum;
    logic de;
    logic ce;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int checks = 0, fails = 0, pushes = 0, pops = 0;
  int tb_cyc;
  logic [3:0] cur_ph = 4'b0001;
  logic [FW-1:0] exp_fr = '0;
  logic signed [UW-1:0] exp_cum = '0;

  always @(posedge clk) if (rst) tb_cyc <= 0; else tb_cyc <= tb_cyc + 1;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && phase_start && q.size() > 0) begin
      e = q.pop_front();
      pops++;
      chk("R2 phase", phase, e.ph);
      chk("R6 frame_no", frame_no, e.fr);
      chk("R7 cum_corr", cum_corr, e.cum);
      chk("R4 dur_err", dur_err, e.de);
      chk("R8 corr_err", corr_err, e.ce);
      chk("R9 sync_time", sync_time, longint'(tb_cyc) + longint'(e.cum));
    end
  end

  task automatic push(exp_t it);
    q.push_back(it);
    pushes++;
  endtask

  task automatic run_np(int n, int lo, int hi, bit junk);
    for (int i = 1; i <= n; i++) begin
      if (i == 2) chk("R3 mid-phase start", phase_start, 0);
      if (junk && i == 2) begin
        corr_valid = 1'b1;   // R5: stray correction outside sync
        corr_value = 8'sd10;
      end
      if (i == n) begin
        phase_done = 1'b1;
        cur_ph = {cur_ph[2:0], cur_ph[3]};
        push('{ph: cur_ph, fr: exp_fr, cum: exp_cum, de: (n < lo || n > hi), ce: 1'b0});
      end
      @(negedge clk);
      phase_done = 1'b0;
      corr_valid = 1'b0;
    end
  endtask

  task automatic run_sync(int n, logic signed [CW-1:0] v, bit junk);
    int mag;
    for (int i = 1; i <= n; i++) begin
      if (i < n && junk) phase_done = 1'b1;   // R5: stray done during sync
      if (i == n) begin
        corr_valid = 1'b1;
        corr_value = v;
        mag = (v < 0) ? -int'(v) : int'(v);
        exp_fr = exp_fr + 1'b1;
        if (mag < 64) exp_cum = exp_cum + UW'(v);
        cur_ph = 4'b0001;
        push('{ph: cur_ph, fr: exp_fr, cum: exp_cum, de: 1'b0, ce: (mag >= 64)});
      end
      @(negedge clk);
      phase_done = 1'b0;
      corr_valid = 1'b0;
    end
  endtask

  task automatic frame(int c, int b, int vt, int sn, logic signed [CW-1:0] v, bit junk);
    run_np(c, 28, 36, junk);
    if (junk) begin
      chk("R5 cum after stray correction", cum_corr, exp_cum);
      chk("R5 frame after stray correction", frame_no, exp_fr);
    end
    run_np(b, 14, 18, 1'b0);
    run_np(vt, 21, 27, 1'b0);
    run_sync(sn, v, junk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phase", phase, 4'b0001);
    chk("R1 frame_no", frame_no, 0);
    chk("R1 cum_corr", cum_corr, 0);
    chk("R1 sync_time", sync_time, 0);
    chk("R1 dur_err", dur_err, 0);
    chk("R1 corr_err", corr_err, 0);
    chk("R1 phase_start", phase_start, 1);
    rst = 1'b0;
    chk("R10 cfg_err", cfg_err, 0);
    frame(32, 16, 24, 3, 8'sd5, 1'b0);
    frame(27, 19, 21, 1, -8'sd63, 1'b0);
    frame(36, 14, 28, 2, 8'sd64, 1'b0);
    frame(28, 18, 27, 4, -8'sd64, 1'b1);
    frame(37, 13, 20, 1, 8'sd63, 1'b0);
    frame(1, 16, 24, 2, -8'sd128, 1'b0);
    repeat (2) @(negedge clk);
    chk("R3 every phase start observed", pops, pushes);
    chk("R10 cfg_err held", cfg_err, 0);
    finish_run();
  end
endmodule